// File: doc/BRIEF.md
# Change-Detecting Charge-Sharing Line Predecoder

This block is a 2-to-4 predecoder whose four output lines are described as digital controls rather than analog voltages. Each line has three enables: one that pulls it high, one that pulls it low, and one that closes a switch onto a shared node. On a new address, the line being deselected and the line being selected pass charge to each other through that node before either is driven again. In steady state exactly one line is driven high. Each line keeps its last driven level in a flip-flop. An exclusive-OR compares that level with the freshly decoded value, and the result marks the lines whose level is about to change.

A new address is taken only at a clock edge where both the share-phase strobe and the address-latch strobe are high. From the next cycle on, the marked lines have their share switch closed and both drivers off, for as long as the share phase stays high. Lines that are not marked keep being driven. At the first edge with the share phase low, the switches open, the old line is driven low and the new line is driven high. A wordline-enable output is held low throughout the share phase and rises one cycle after every line has returned to a full level. Downstream row decoders therefore never see a line resting at the half level.

Top module: `cs_predec`

## Requirements
- R1: While reset is low, line 0 is driven high (drive-high = 4'b0001), lines 1 to 3 are driven low (drive-low = 4'b1110), no share enable is set and wordline-enable is 0. At the first clock edge after reset is released, wordline-enable becomes 1.
- R2: A clock edge with the share strobe low takes no address, whatever the latch strobe is. A clock edge with the latch strobe low also takes no address. After such an edge the drive and share outputs are unchanged, unless that edge ends a share phase.
- R3: After an edge that takes an address decoding to a line other than the currently driven one, the share enables (bit i = line i, line i selected by address value i) hold exactly the old line and the new line. Those two lines have both drivers off, and every other line keeps its previous drive.
- R4: Taking an address equal to the currently driven line marks no line. No share enable is set, and all outputs, including wordline-enable, keep their values.
- R5: At the first edge where the share strobe is low while share enables are set, all share enables clear, the new line is driven high and the old line is driven low.
- R6: Wordline-enable falls at the same edge as the share enables are set. It stays 0 while any share enable is set, and it rises exactly one cycle after the share enables clear.
- R7: On any one line, the share enable is never active in the same cycle as that line's drive-high or drive-low enable.
- R8: An address taken while a share phase is still open is compared with the last fully driven line, not with the previous pending target. If it equals the driven line, all share enables clear and drives are restored.
- R9: Whenever wordline-enable is 1, exactly one line is driven high and no line is at the shared half level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Address to decode, taken only on a qualified edge |
| share_i | input | 1 | Share-phase strobe; high while lines may exchange charge |
| latch_i | input | 1 | Address-latch strobe; effective only with share_i high |
| drv_hi_o | output | 4 | Per-line pull-high enable |
| drv_lo_o | output | 4 | Per-line pull-low enable |
| shr_en_o | output | 4 | Per-line share-switch enable |
| wl_en_o | output | 1 | Wordline enable for the downstream decoder |

## Verification
A corrupted held-line register shows up as an error in both drive vectors in the very cycle after the corrupting edge. It also shows up one address change later, as a wrong pair of share enables, because every change flag is computed against that register. A stuck or wrong change flag shows up in the first cycle of a share phase, either as a share pattern that does not have exactly two bits set or as a line that is shared and driven at the same time. A wordline-enable timing fault is visible one edge after a share phase opens or closes. The vector walk therefore samples every cycle around each phase boundary.

// File: rtl/cs_predec_pkg.sv
package cs_predec_pkg;

    localparam int unsigned PD_ADDR_W = 2;
    localparam int unsigned PD_LINES  = 1 << PD_ADDR_W;

    // Abstract level of one line, used to reason about charge sharing
    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HALF = 2'd1,
        LVL_HIGH = 2'd2
    } line_lvl_e;

endpackage

// File: rtl/cs_predec_decode.sv
module cs_predec_decode #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned LINES  = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LINES-1:0]  held_i,
    output logic [LINES-1:0]  hot_o,
    output logic [LINES-1:0]  diff_o
);

    // One comparator and one change detector per line
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign hot_o[i]  = (addr_i == ADDR_W'(i));
        assign diff_o[i] = hot_o[i] ^ held_i[i];
    end

endmodule

// File: rtl/cs_predec_lane.sv
module cs_predec_lane (
    input  logic held_i,
    input  logic flag_i,
    output logic hi_o,
    output logic lo_o,
    output logic shr_o
);

    // A flagged line floats onto the share node; otherwise it is driven
    assign shr_o = flag_i;
    assign hi_o  = held_i & ~flag_i;
    assign lo_o  = ~held_i & ~flag_i;

endmodule

// File: rtl/cs_predec.sv
module cs_predec #(
    parameter int unsigned ADDR_W = cs_predec_pkg::PD_ADDR_W,
    localparam int unsigned LINES = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              share_i,
    input  logic              latch_i,
    output logic [LINES-1:0]  drv_hi_o,
    output logic [LINES-1:0]  drv_lo_o,
    output logic [LINES-1:0]  shr_en_o,
    output logic              wl_en_o
);

    typedef struct packed {
        logic [LINES-1:0] held;    // last fully driven one-hot value
        logic [LINES-1:0] target;  // pending one-hot value
        logic [LINES-1:0] flag;    // lines currently on the share node
        logic             wl_en;
    } pd_state_t;

    pd_state_t st_d, st_q;

    logic [LINES-1:0] hot;
    logic [LINES-1:0] diff;
    logic             take;

    cs_predec_decode #(
        .ADDR_W (ADDR_W),
        .LINES  (LINES)
    ) u_decode (
        .addr_i (addr_i),
        .held_i (st_q.held),
        .hot_o  (hot),
        .diff_o (diff)
    );

    assign take = share_i & latch_i;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.target = hot;
            st_d.flag   = diff;
        end else if (!share_i && (st_q.flag != '0)) begin
            st_d.held = st_q.target;
            st_d.flag = '0;
        end
        // Enable only after a full cycle with every line at a rail
        st_d.wl_en = (st_q.flag == '0) && (st_d.flag == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.held   <= LINES'(1);
            st_q.target <= LINES'(1);
            st_q.flag   <= '0;
            st_q.wl_en  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_lane
        cs_predec_lane u_lane (
            .held_i (st_q.held[i]),
            .flag_i (st_q.flag[i]),
            .hi_o   (drv_hi_o[i]),
            .lo_o   (drv_lo_o[i]),
            .shr_o  (shr_en_o[i])
        );
    end

    assign wl_en_o = st_q.wl_en;

endmodule

// File: rtl/cs_predec_chk.sv
module cs_predec_chk #(
    parameter int unsigned LINES = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             share_i,
    input logic [LINES-1:0] drv_hi_o,
    input logic [LINES-1:0] drv_lo_o,
    input logic [LINES-1:0] shr_en_o,
    input logic             wl_en_o
);

    assert_break_before_make_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shr_en_o & (drv_hi_o | drv_lo_o)) == '0);

    assert_no_double_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drv_hi_o & drv_lo_o) == '0);

    assert_pair_shared_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(shr_en_o) == 0) || ($countones(shr_en_o) == 2));

    assert_phase_end_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !share_i |=> (shr_en_o == '0));

    assert_wl_low_in_share_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shr_en_o != '0) |-> !wl_en_o);

    assert_wl_gap_after_share_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shr_en_o != '0) |=> !wl_en_o);

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!share_i && (shr_en_o == '0)) |=> ($stable(drv_hi_o) && $stable(shr_en_o)));

    assert_single_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wl_en_o |-> ($countones(drv_hi_o) == 1));

endmodule

bind cs_predec cs_predec_chk #(.LINES(LINES)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .share_i  (share_i),
    .drv_hi_o (drv_hi_o),
    .drv_lo_o (drv_lo_o),
    .shr_en_o (shr_en_o),
    .wl_en_o  (wl_en_o)
);

// File: tb/cs_predec_bench.sv
`timescale 1ns/100ps
module cs_predec_bench;
    import cs_predec_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       share = 1'b0;
    logic       latch = 1'b0;
    logic [3:0] drv_hi, drv_lo, shr_en;
    logic       wl_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cs_predec u_cs_predec (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .addr_i   (addr),
        .share_i  (share),
        .latch_i  (latch),
        .drv_hi_o (drv_hi),
        .drv_lo_o (drv_lo),
        .shr_en_o (shr_en),
        .wl_en_o  (wl_en)
    );

    // {share, latch, addr, exp_hi, exp_lo, exp_shr, exp_wl, req}
    localparam int NV = 19;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {1'b0,1'b0,2'd0,4'b0001,4'b1110,4'b0000,1'b1,4'd1}, // R1 wl rises
        {1'b0,1'b1,2'd2,4'b0001,4'b1110,4'b0000,1'b1,4'd2}, // R2 no share
        {1'b1,1'b0,2'd2,4'b0001,4'b1110,4'b0000,1'b1,4'd2}, // R2 no latch
        {1'b1,1'b1,2'd2,4'b0000,4'b1010,4'b0101,1'b0,4'd3}, // R3 0->2
        {1'b0,1'b0,2'd2,4'b0100,4'b1011,4'b0000,1'b0,4'd5}, // R5 drive
        {1'b0,1'b0,2'd2,4'b0100,4'b1011,4'b0000,1'b1,4'd6}, // R6 rise
        {1'b1,1'b1,2'd2,4'b0100,4'b1011,4'b0000,1'b1,4'd4}, // R4 same
        {1'b0,1'b0,2'd2,4'b0100,4'b1011,4'b0000,1'b1,4'd4}, // R4 hold
        {1'b1,1'b1,2'd3,4'b0000,4'b0011,4'b1100,1'b0,4'd3}, // R3 2->3
        {1'b1,1'b1,2'd1,4'b0000,4'b1001,4'b0110,1'b0,4'd8}, // R8 retarget
        {1'b1,1'b0,2'd0,4'b0000,4'b1001,4'b0110,1'b0,4'd6}, // R6 share held
        {1'b0,1'b0,2'd0,4'b0010,4'b1101,4'b0000,1'b0,4'd5}, // R5 drive 1
        {1'b0,1'b1,2'd0,4'b0010,4'b1101,4'b0000,1'b1,4'd2}, // R2 ignored
        {1'b1,1'b1,2'd0,4'b0000,4'b1100,4'b0011,1'b0,4'd3}, // R3 1->0
        {1'b0,1'b1,2'd3,4'b0001,4'b1110,4'b0000,1'b0,4'd5}, // R5 latch ignored
        {1'b0,1'b0,2'd0,4'b0001,4'b1110,4'b0000,1'b1,4'd9}, // R9 settled
        {1'b1,1'b1,2'd2,4'b0000,4'b1010,4'b0101,1'b0,4'd3}, // R3 0->2
        {1'b1,1'b1,2'd0,4'b0001,4'b1110,4'b0000,1'b0,4'd8}, // R8 back to held
        {1'b1,1'b0,2'd0,4'b0001,4'b1110,4'b0000,1'b1,4'd6}  // R6 rise
    };

    task automatic check(input int req, input logic [3:0] hi, input logic [3:0] lo,
                         input logic [3:0] sh, input logic wl, input string tag);
        n_cmp++;
        if (drv_hi !== hi || drv_lo !== lo || shr_en !== sh || wl_en !== wl) begin
            n_bad++;
            $display("FAIL R%0d %s: hi=%b lo=%b shr=%b wl=%b expected hi=%b lo=%b shr=%b wl=%b",
                     req, tag, drv_hi, drv_lo, shr_en, wl_en, hi, lo, sh, wl);
        end
    endtask

    // R9: line levels seen by the row decoder when enabled
    task automatic check_levels();
        int highs = 0;
        int halves = 0;
        for (int i = 0; i < 4; i++) begin
            line_lvl_e lv;
            lv = shr_en[i] ? LVL_HALF : (drv_hi[i] ? LVL_HIGH : LVL_LOW);
            if (lv == LVL_HIGH) highs++;
            if (lv == LVL_HALF) halves++;
        end
        if (wl_en) begin
            n_cmp++;
            if (highs != 1 || halves != 0) begin
                n_bad++;
                $display("FAIL R9 levels: highs=%0d halves=%0d expected highs=1 halves=0",
                         highs, halves);
            end
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check(1, 4'b0001, 4'b1110, 4'b0000, 1'b0, "in reset R1");
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            share = VEC[v][20];
            latch = VEC[v][19];
            addr  = VEC[v][18:17];
            @(posedge clk);
            #1;
            check(int'(VEC[v][3:0]), VEC[v][16:13], VEC[v][12:9], VEC[v][8:5],
                  VEC[v][4], $sformatf("vector %0d", v));
            check_levels();
        end

        // Reset during an open share phase (R1)
        share = 1'b1; latch = 1'b1; addr = 2'd3;
        @(posedge clk);
        #1;
        check(3, 4'b0000, 4'b0110, 4'b1001, 1'b0, "share 0->3 before reset R3");
        rst_n = 1'b0;
        #1;
        check(1, 4'b0001, 4'b1110, 4'b0000, 1'b0, "async reset mid-share R1");
        share = 1'b0; latch = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(1, 4'b0001, 4'b1110, 4'b0000, 1'b1, "wl after second release R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule